// File: doc/BRIEF.md
# Ethernet Pause Interval Timer

This block holds off a transmit MAC for the time a received flow-control pause frame asks for. It can also hold it off for a time that software loads by hand. An upstream parser delivers a one-cycle strobe with the already-extracted 16-bit pause quanta. A separate slot-time tick paces the countdown. While the count is nonzero the block asserts a hold output toward the transmitter.

Pause reception is armed when a software enable is set or a negotiated-pause flag is set. Turning the software enable off cuts any running interval short. Software sees a live copy of the counter and a packed status word. It can start an interval by hand, but only while the timer is idle.

Top module: `pause_interval_timer`

## Requirements
- R1: After reset the count is 0, `tx_hold` is 0 and the received and active status bits are 0.
- R2: A pause frame strobe is taken only when `sw_pause_en` or `neg_pause_ok` is 1. Otherwise it leaves count and status untouched.
- R3: If `sw_pause_en` was 1 on one clock edge and is 0 on the next, that next edge clears the count and the received status. This happens even when `neg_pause_ok` is 1.
- R4: A taken frame with nonzero quanta loads the count on the next edge and sets active and received. Received stays set for as long as the count is nonzero.
- R5: While the count is nonzero, each `slot_tick` lowers it by exactly one. The edge that takes it from 1 to 0 ends the interval and clears received.
- R6: A manual load with a nonzero value, made while neither received nor active is set, loads the count and starts an interval. Received stays 0.
- R7: A manual load made while the timer is active or received is set has no effect.
- R8: A value of 0 from either source starts no interval. A taken frame with quanta 0 during an interval ends that interval on the next edge.
- R9: A frame taken during an interval restarts the count at the new quanta.
- R10: `status_word` bits [15:0] hold the live count. Bit 16 is the manual-load bit and always reads 0. Bit 17 is active, bit 18 is received, and bit 19 is 1 when reception is enabled.
- R11: When several events fall on the same edge, they are applied in this order: termination, then a taken frame, then a manual load, then a tick. Only the first of these takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_pause_en | input | 1 | Software pause enable |
| neg_pause_ok | input | 1 | Pause agreed by link negotiation |
| pframe_valid | input | 1 | One-cycle strobe: pause frame received |
| pframe_quanta | input | 16 | Quanta carried by the frame |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| man_load | input | 1 | Software write with the manual-load bit set |
| man_value | input | 16 | Count written with the manual load |
| tx_hold | output | 1 | Holds off the transmit MAC while 1 |
| count_live | output | 16 | Current counter value |
| status_word | output | 20 | Packed status read by software (layout in R10) |

## Verification
The count register feeds `count_live`, `tx_hold` and the status word directly. A wrong count, a missed decrement or a stray reload therefore shows at the ports on the very next clock. A received flag that sticks or drops too early shows up just as fast in status bit 18. A broken termination path is only visible when the software enable falls while an interval runs. The bench therefore compares every port against a cycle model on every clock, across enable falls, back-to-back frames and same-edge collisions.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_CLEAR,
    ACT_FRAME,
    ACT_MANUAL,
    ACT_TICK
  } pit_act_e;

  // Fixed priority among same-edge events.
  function automatic pit_act_e pick_action(input logic terminate,
                                           input logic frame_take,
                                           input logic ld_go,
                                           input logic tick_go);
    if (terminate)       return ACT_CLEAR;
    else if (frame_take) return ACT_FRAME;
    else if (ld_go)      return ACT_MANUAL;
    else if (tick_go)    return ACT_TICK;
    else                 return ACT_HOLD;
  endfunction

endpackage

// File: rtl/pit_enable_ctrl.sv
module pit_enable_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_pause_en,
  input  logic neg_pause_ok,
  output logic rx_enabled,
  output logic terminate
);

  logic sw_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_prev <= 1'b0;
    else        sw_prev <= sw_pause_en;
  end

  assign rx_enabled = sw_pause_en | neg_pause_ok;
  assign terminate  = sw_prev & ~sw_pause_en;

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             terminate,
  input  logic             frame_take,
  input  logic [CNT_W-1:0] frame_quanta,
  input  logic             ld_req,
  input  logic [CNT_W-1:0] ld_value,
  input  logic             slot_tick,
  output logic [CNT_W-1:0] count,
  output logic             rcvd,
  output logic             active
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - ONE;
  endfunction

  function automatic logic is_last_slot(input logic [CNT_W-1:0] c);
    return c == ONE;
  endfunction

  logic     ld_go;
  logic     tick_go;
  pit_act_e act;

  assign active  = |count;
  assign ld_go   = ld_req & ~active & ~rcvd;
  assign tick_go = slot_tick & active;
  assign act     = pick_action(terminate, frame_take, ld_go, tick_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      rcvd  <= 1'b0;
    end else begin
      case (act)
        ACT_CLEAR: begin
          count <= '0;
          rcvd  <= 1'b0;
        end
        ACT_FRAME: begin
          count <= frame_quanta;
          rcvd  <= |frame_quanta;
        end
        ACT_MANUAL: count <= ld_value;
        ACT_TICK: begin
          count <= step_down(count);
          if (is_last_slot(count)) rcvd <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  AST_TERM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    terminate |=> (count == '0 && !rcvd)); // R3

  AST_RCVD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rcvd |-> active); // R4

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot_tick && !terminate && !frame_take) |=> count == $past(count) - ONE); // R5

  AST_MANUAL_NO_RCVD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !active && !rcvd && !terminate && !frame_take) |=> !rcvd); // R6

  AST_LOAD_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && active && !terminate && !frame_take && !slot_tick) |=> $stable(count)); // R7

  AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_take && !terminate) |=> count == $past(frame_quanta)); // R9

endmodule

// File: rtl/pause_interval_timer.sv
module pause_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_pause_en,
  input  logic             neg_pause_ok,
  input  logic             pframe_valid,
  input  logic [CNT_W-1:0] pframe_quanta,
  input  logic             slot_tick,
  input  logic             man_load,
  input  logic [CNT_W-1:0] man_value,
  output logic             tx_hold,
  output logic [CNT_W-1:0] count_live,
  output logic [CNT_W+3:0] status_word
);

  localparam int STAT_W = CNT_W + 4;

  logic rx_enabled;
  logic terminate;
  logic frame_take;
  logic rcvd;
  logic active;

  pit_enable_ctrl u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_pause_en (sw_pause_en),
    .neg_pause_ok(neg_pause_ok),
    .rx_enabled  (rx_enabled),
    .terminate   (terminate)
  );

  assign frame_take = pframe_valid & rx_enabled;

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .terminate   (terminate),
    .frame_take  (frame_take),
    .frame_quanta(pframe_quanta),
    .ld_req      (man_load),
    .ld_value    (man_value),
    .slot_tick   (slot_tick),
    .count       (count_live),
    .rcvd        (rcvd),
    .active      (active)
  );

  assign tx_hold = active;

  logic [STAT_W-1:0] stat_pack;
  assign stat_pack   = {rx_enabled, rcvd, active, 1'b0, count_live};
  assign status_word = stat_pack;

  AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pframe_valid && !rx_enabled && !terminate && !man_load && !active) |=> count_live == '0); // R2

endmodule

// File: tb/sim_pause_interval_timer.sv
module sim_pause_interval_timer;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sw = 1'b0, neg = 1'b0, fv = 1'b0, tk = 1'b0, ml = 1'b0;
  logic [15:0] fq = '0, mv = '0;
  logic        hold;
  logic [15:0] cnt_o;
  logic [19:0] stat_o;

  pause_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .sw_pause_en(sw), .neg_pause_ok(neg),
    .pframe_valid(fv), .pframe_quanta(fq), .slot_tick(tk),
    .man_load(ml), .man_value(mv), .tx_hold(hold),
    .count_live(cnt_o), .status_word(stat_o)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    run_chk = 0;
  bit    done = 0;

  // Behavioural reference model
  int m_cnt = 0;
  bit m_rcvd = 0, m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rcvd = 0; m_prev = 0;
    end else begin
      if (m_prev && !sw) begin
        m_cnt = 0; m_rcvd = 0;
      end else if (fv && (sw || neg)) begin
        m_cnt = int'(fq); m_rcvd = (fq != 0);
      end else if (ml && m_cnt == 0 && !m_rcvd) begin
        m_cnt = int'(mv);
      end else if (tk && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_rcvd = 0;
      end
      m_prev = sw;
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      logic [19:0] exp_s;
      exp_s = {(sw || neg), m_rcvd, (m_cnt != 0), 1'b0, 16'(m_cnt)};
      n_chk++;
      if (cnt_o !== 16'(m_cnt) || hold !== (m_cnt != 0) || stat_o !== exp_s) begin
        n_fail++;
        $display("FAIL %s: count=%0d hold=%0b status=%h expected count=%0d hold=%0b status=%h",
                 cur_req, cnt_o, hold, stat_o, m_cnt, (m_cnt != 0), exp_s);
      end
    end
  end

  task automatic cyc(input bit f, input int q, input bit l, input int v, input bit t);
    fv = f; fq = 16'(q); ml = l; mv = 16'(v); tk = t;
    @(posedge clk); #2;
    fv = 0; ml = 0; tk = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    run_chk = 1;
    cur_req = "R1"; idle(3);

    cur_req = "R2"; cyc(1, 5, 0, 0, 0); idle(3);            // disabled: ignored
    cur_req = "R10"; idle(1);                                // bit 16 zero, layout

    sw = 1;
    cur_req = "R4"; cyc(1, 3, 0, 0, 0); idle(2);
    cur_req = "R5"; ticks(4);                                // runs out, received clears

    cur_req = "R6"; cyc(0, 0, 1, 4, 0); idle(1);
    cur_req = "R7"; cyc(0, 0, 1, 9, 0); idle(1);
    cur_req = "R5"; ticks(5);

    cur_req = "R8"; cyc(0, 0, 1, 0, 0); idle(2);             // manual zero
    cyc(1, 0, 0, 0, 0); idle(2);                             // frame zero idle
    cyc(1, 6, 0, 0, 0); ticks(1); cyc(1, 0, 0, 0, 0); idle(2); // zero ends interval

    cur_req = "R9"; cyc(1, 10, 0, 0, 0); ticks(2);
    cyc(1, 2, 0, 0, 0); ticks(3);

    cur_req = "R7"; cyc(1, 8, 0, 0, 0); cyc(0, 0, 1, 3, 1); idle(1);
    ticks(8);

    cur_req = "R11"; cyc(1, 4, 0, 0, 1); idle(1);            // frame beats tick
    ticks(4);
    cyc(1, 7, 1, 2, 0); idle(1);                             // frame beats manual
    ticks(7);

    cur_req = "R3"; neg = 1; cyc(1, 20, 0, 0, 0); ticks(2);
    sw = 0; idle(3);                                         // terminated with neg set
    cur_req = "R2"; cyc(1, 5, 0, 0, 0); ticks(2);            // neg alone enables
    cur_req = "R11"; sw = 1; idle(1); sw = 0;
    cyc(1, 9, 0, 0, 0); idle(2);                             // termination beats frame
    cur_req = "R3"; cyc(1, 3, 0, 0, 0); ticks(4);            // sw stays low: no kill

    neg = 0;
    cur_req = "R2"; cyc(1, 4, 0, 0, 0); idle(2);
    cur_req = "R6"; cyc(0, 0, 1, 2, 0); ticks(3);

    done = 1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
    end
  end

endmodule